// File: doc/BRIEF.md
# Isochronous Cycle Timer with Extended Bus Time

This block keeps a free-running isochronous cycle timer and extends it with a 32-bit bus-time count of whole seconds. The timer word has three fields. The low field is a sub-cycle offset that advances on each `tick_i` pulse, which is a 24.576 MHz enable. The middle field is a cycle count. The top field is a 7-bit seconds count. Each field carries into the next when it wraps.

The bus-time register stores its upper 25 bits together with a copy of the last seen top bit of the seconds field. When that bit changes, the block raises a one-cycle event. The event sets a sticky status flag and adds 0x40 to the stored value, so the stored copy comes back into line and the carry moves into the upper bits. A bus-time read performs the same check before it returns its value.

Software reaches the block through a simple register port. The address field selects one of three registers:
- 0: cycle time
- 1: bus time
- 2: status

Read data is registered and appears on `rdata_o` one clock after `rd_i`. It holds that value until the next read. An init strobe loads a seconds value into both the timer and the bus time.

Top module: `cycle_bus_timer`

## Requirements
- R1: The timer word holds the offset in bits 11:0 (range 0..3071), the cycle count in bits 24:12 (range 0..7999) and the seconds in bits 31:25. Reading address 0 returns this word.
- R2: Each clock with `tick_i` high advances the offset by one. When the offset is at 3071 it wraps to 0 and the cycle count advances. When the count wraps after 7999, the seconds advance. The seconds wrap from 127 to 0.
- R3: `evt64_o` is high for exactly one clock, the clock after the edge at which timer bit 31 changed value.
- R4: Status bit 0 (address 2) is set by `evt64_o`. A write with data bit 0 equal to 1 clears it. A write with data bit 0 equal to 0 leaves it unchanged.
- R5: A bus-time read (address 1) returns the stored value ORed with the current 7-bit seconds field in bits 6:0.
- R6: On an event, and on every bus-time read, if stored bit 6 differs from timer bit 31, the stored value is increased by 0x40.
- R7: A bus-time write replaces stored bits 31:7 with data bits 31:7 and keeps stored bits 6:0.
- R8: `init_i` loads the timer with `init_sec_i` shifted left by 25, loads the bus time with `init_sec_i` with bits 5:0 cleared, and raises no event.
- R9: A cycle-time write (address 0) loads all three fields at once. An offset above 3071 is clamped to 3071 and a count above 7999 is clamped to 7999. The write overrides a tick in the same clock.
- R10: A bus-time read in the same clock as an event returns the value with the carry already applied. The 0x40 is added only once.
- R11: After reset the timer, the bus time, the status flag, `evt64_o` and `rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer advance enable (24.576 MHz rate) |
| init_i | input | 1 | Load seconds into timer and bus time |
| init_sec_i | input | 32 | Seconds value used by init |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 cycle time, 1 bus time, 2 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt64_o | output | 1 | Pulse on each change of timer bit 31 |

## Verification
Two things can happen in the same clock: a bus-time read and the carry update triggered by a 64-second event. Both want to update the stored bus time. The bench first writes the timer to 63 s, cycle 7999, offset 3071, with ticks stopped. It then issues a single tick and asserts the bus-time read in the clock where `evt64_o` is high. The result is correct if the returned word includes exactly one 0x40 carry, and a second read returns the same word.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int OFF_W = 12;
  localparam int CNT_W = 13;
  localparam int SEC_W = 7;
  localparam int WORD_W = OFF_W + CNT_W + SEC_W;
  localparam int SEC_LSB = OFF_W + CNT_W;
  localparam int CARRY_BIT = SEC_W - 1;

  typedef enum logic [1:0] {
    ADDR_CYC  = 2'd0,
    ADDR_BUS  = 2'd1,
    ADDR_STAT = 2'd2
  } cbt_addr_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CNT_W-1:0] cnt;
    logic [OFF_W-1:0] off;
  } cyc_word_t;
endpackage

// File: rtl/cbt_cycle_ctr.sv
module cbt_cycle_ctr
  import cbt_pkg::*;
#(
  parameter int OFFSET_MAX = 3071,
  parameter int COUNT_MAX  = 7999
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  cyc_word_t load_val_i,
  output cyc_word_t cyc_o
);
  localparam logic [OFF_W-1:0] OffLast = OFF_W'(OFFSET_MAX);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(COUNT_MAX);

  cyc_word_t cyc_q, cyc_d;
  logic off_wrap, cnt_wrap;

  assign off_wrap = (cyc_q.off == OffLast);
  assign cnt_wrap = (cyc_q.cnt == CntLast);

  always_comb begin
    cyc_d = cyc_q;
    if (load_i) begin
      cyc_d = load_val_i;
    end else if (tick_i) begin
      cyc_d.off = off_wrap ? '0 : cyc_q.off + 1'b1;
      if (off_wrap) begin
        cyc_d.cnt = cnt_wrap ? '0 : cyc_q.cnt + 1'b1;
        if (cnt_wrap) cyc_d.sec = cyc_q.sec + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_d;
  end

  assign cyc_o = cyc_q;

  p_offset_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q.off <= OffLast);
  p_count_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q.cnt <= CntLast);
  p_offset_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !off_wrap) |=> (cyc_q.off == $past(cyc_q.off) + 1'b1));
  p_sec_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && off_wrap && cnt_wrap) |=>
      (cyc_q.sec == $past(cyc_q.sec) + 1'b1));
endmodule

// File: rtl/cbt_evt.sv
module cbt_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic msb_i,
  input  logic init_i,
  input  logic init_msb_i,
  input  logic cyc_load_i,
  input  logic clr_i,
  output logic evt_o,
  output logic sticky_o
);
  logic msb_q, sticky_q;

  assign evt_o = msb_i ^ msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      msb_q <= init_i ? init_msb_i : msb_i;
      if (evt_o)      sticky_q <= 1'b1;
      else if (clr_i) sticky_q <= 1'b0;
    end
  end

  assign sticky_o = sticky_q;

  p_evt_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !cyc_load_i && !init_i) |=> !evt_o);
  p_sticky_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> sticky_q);
endmodule

// File: rtl/cbt_bus_ext.sv
module cbt_bus_ext
  import cbt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             sync_i,
  input  logic             wr_i,
  input  logic [31:7]      wdata_hi_i,
  input  logic             init_i,
  input  logic [31:6]      init_hi_i,
  output logic [31:0]      rd_val_o
);
  logic [31:0] bt_q, bt_upd, bt_d;
  logic        need_carry;

  assign need_carry = sync_i && (bt_q[CARRY_BIT] != sec_i[CARRY_BIT]);
  assign bt_upd     = need_carry ? bt_q + 32'h40 : bt_q;

  always_comb begin
    bt_d = bt_upd;
    if (init_i)    bt_d = {init_hi_i, 6'b0};
    else if (wr_i) bt_d = {wdata_hi_i, bt_upd[6:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bt_q <= '0;
    else         bt_q <= bt_d;
  end

  assign rd_val_o = bt_upd | {25'b0, sec_i};

  p_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (need_carry && !init_i) |=> (bt_q[CARRY_BIT] == $past(sec_i[CARRY_BIT])));
  p_write_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !init_i && !sync_i) |=>
      (bt_q[31:7] == $past(wdata_hi_i) && bt_q[6:0] == $past(bt_q[6:0])));
endmodule

// File: rtl/cycle_bus_timer.sv
module cycle_bus_timer
  import cbt_pkg::*;
#(
  parameter int OFFSET_MAX = 3071,
  parameter int COUNT_MAX  = 7999
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        init_i,
  input  logic [31:0] init_sec_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        evt64_o
);
  localparam logic [OFF_W-1:0] OffLast = OFF_W'(OFFSET_MAX);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(COUNT_MAX);

  cyc_word_t   cyc, wr_word, load_word;
  logic        wr_cyc, wr_bus, wr_stat, rd_bus, cyc_load, sticky;
  logic [31:0] bus_val, rd_mux, rdata_q;

  assign wr_cyc  = wr_i && (addr_i == ADDR_CYC);
  assign wr_bus  = wr_i && (addr_i == ADDR_BUS);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign rd_bus  = rd_i && (addr_i == ADDR_BUS) && !init_i;

  always_comb begin
    wr_word     = wdata_i;
    wr_word.off = (wr_word.off > OffLast) ? OffLast : wr_word.off;
    wr_word.cnt = (wr_word.cnt > CntLast) ? CntLast : wr_word.cnt;
  end

  assign cyc_load  = init_i || wr_cyc;
  assign load_word = init_i ? cyc_word_t'({init_sec_i[SEC_W-1:0], 25'b0}) : wr_word;

  cbt_cycle_ctr #(.OFFSET_MAX(OFFSET_MAX), .COUNT_MAX(COUNT_MAX)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (cyc_load),
    .load_val_i (load_word),
    .cyc_o      (cyc)
  );

  cbt_evt u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msb_i      (cyc.sec[CARRY_BIT]),
    .init_i     (init_i),
    .init_msb_i (init_sec_i[CARRY_BIT]),
    .cyc_load_i (cyc_load),
    .clr_i      (wr_stat && wdata_i[0]),
    .evt_o      (evt64_o),
    .sticky_o   (sticky)
  );

  cbt_bus_ext u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_i      (cyc.sec),
    .sync_i     (evt64_o || rd_bus),
    .wr_i       (wr_bus),
    .wdata_hi_i (wdata_i[31:7]),
    .init_i     (init_i),
    .init_hi_i  (init_sec_i[31:6]),
    .rd_val_o   (bus_val)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CYC:  rd_mux = cyc;
      ADDR_BUS:  rd_mux = bus_val;
      ADDR_STAT: rd_mux = {31'b0, sticky};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_write_beats_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cyc && !init_i) |=> (cyc == $past(wr_word)));
  p_init_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !evt64_o);
endmodule

// File: tb/sim_cycle_bus_timer.sv
module sim_cycle_bus_timer;
  logic        clk = 0, rst_n = 0;
  logic        tick = 0, init = 0, rd = 0, wr = 0;
  logic [31:0] init_sec = 0, wdata = 0;
  logic [1:0]  addr = 0;
  logic [31:0] rdata;
  logic        evt;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  cycle_bus_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .init_i(init),
    .init_sec_i(init_sec), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt64_o(evt)
  );

  function automatic logic [31:0] pk(int s, int c, int o);
    return {s[6:0], c[12:0], o[11:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d, logic with_tick);
    @(negedge clk); wr = 1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk); wr = 0; tick = 0;
  endtask

  task automatic run_ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset();
    chk("R11 evt", {31'b0, evt}, 0);
    chk("R11 rdata", rdata, 0);
    rd_reg(0, v); chk("R11 cyc", v, 0);
    rd_reg(1, v); chk("R11 bus", v, 0);
    rd_reg(2, v); chk("R11 stat", v, 0);
  endtask

  task automatic t_count();
    run_ticks(5);
    rd_reg(0, v); chk("R2 offset", v, pk(0, 0, 5));
    wr_reg(0, pk(5, 10, 3070), 0);
    run_ticks(2);
    rd_reg(0, v); chk("R2 offset wrap", v, pk(5, 11, 0));
    wr_reg(0, pk(5, 7999, 3071), 0);
    run_ticks(1);
    rd_reg(0, v); chk("R1 R2 count wrap", v, pk(6, 0, 0));
  endtask

  task automatic t_clamp();
    wr_reg(0, pk(3, 8191, 4095), 1);
    rd_reg(0, v); chk("R9 clamp", v, pk(3, 7999, 3071));
    wr_reg(0, pk(4, 7000, 3100), 1);
    rd_reg(0, v); chk("R9 offset clamp", v, pk(4, 7000, 3071));
  endtask

  task automatic t_init();
    @(negedge clk); init = 1; init_sec = 32'h1234_5678;
    @(negedge clk); init = 0;
    chk("R8 no evt", {31'b0, evt}, 0);
    rd_reg(0, v); chk("R8 cyc", v, pk(8'h78, 0, 0));
    rd_reg(1, v); chk("R8 R5 bus", v, 32'h1234_5678);
  endtask

  task automatic t_sec_wrap();
    wr_reg(0, pk(127, 7999, 3071), 0);
    chk("R3 no evt same msb", {31'b0, evt}, 0);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    chk("R3 evt high", {31'b0, evt}, 1);
    @(negedge clk);
    chk("R3 evt one cycle", {31'b0, evt}, 0);
    rd_reg(0, v); chk("R2 sec wrap", v, pk(0, 0, 0));
    rd_reg(1, v); chk("R6 carry", v, 32'h1234_5680);
  endtask

  task automatic t_read_with_evt();
    wr_reg(0, pk(63, 7999, 3071), 0);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; rd = 1; addr = 1;
    chk("R3 evt at read", {31'b0, evt}, 1);
    @(negedge clk); rd = 0;
    chk("R10 read with evt", rdata, 32'h1234_56C0);
    rd_reg(1, v); chk("R10 single add", v, 32'h1234_56C0);
  endtask

  task automatic t_bus_write();
    wr_reg(1, 32'hABCD_EFFF, 0);
    rd_reg(1, v); chk("R7 bus write", v, 32'hABCD_EFC0);
    wr_reg(1, 32'h0000_0000, 0);
    rd_reg(1, v); chk("R7 R5 low kept", v, 32'h0000_0040);
  endtask

  task automatic t_status();
    rd_reg(2, v); chk("R4 sticky", v, 1);
    wr_reg(2, 0, 0);
    rd_reg(2, v); chk("R4 write 0", v, 1);
    wr_reg(2, 1, 0);
    rd_reg(2, v); chk("R4 clear", v, 0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_clamp();
    t_init();
    t_sec_wrap();
    t_read_with_evt();
    t_bus_write();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule